// File: doc/BRIEF.md
# Raster Dot and Line Timing Generator

This block is the beam-position clock of a tile-based picture processor. It advances a dot counter once per clock across a scanline of 341 dots, numbered 0 to 340. It advances a line counter at the end of each scanline, and it flips a frame-parity bit each time a frame wraps back to dot 0 of line 0. The last line of every frame is the pre-render line. On that line, while rendering is on, the block raises a strobe over dots 280 to 304. The strobe tells the scroll logic to copy the vertical scroll bits (address mask 0x7BE0) from the temporary address into the current address. Tile-prefetch strobes fire at dots 321 and 329 on every fetching line.

Two line-count standards are selectable. In short-frame mode (`short_mode` = 1) the frame has `LINES_SHORT` lines, 262 by default. On frames with odd parity, with rendering enabled, the pre-render line loses its final dot, so the frame takes 89341 clocks instead of 89342. The skip decision is taken at dot 338 of the pre-render line and held in a flag, so a change to rendering enable at dot 339 cannot undo it. In fixed mode (`short_mode` = 0) the frame has `LINES_FIXED` lines, 312 by default, and never shortens.

Line sequencing is a three-state machine. ST_ACTIVE covers every line before the pre-render line. ST_PRERENDER is the pre-render line with no skip pending. ST_ARMED is the pre-render line with the skip latched. The transitions are:
- ACTIVE to PRERENDER, at dot 340 of the line just before the pre-render line.
- PRERENDER to ARMED, at dot 338 when the mode is short, rendering is on and parity is odd.
- PRERENDER to ACTIVE, at dot 340. This is the normal frame wrap.
- ARMED to ACTIVE, at dot 339. This is the shortened frame wrap, and it clears the flag.

Top module: `raster_timing_gen`

## Requirements
- R1: `dot` counts 0, 1, … 340 and then returns to 0. The line counter advances only when `dot` wraps from 340.
- R2: A frame has `LINES_SHORT` lines when `short_mode`=1 and `LINES_FIXED` lines when `short_mode`=0. The pre-render line is index count−1, and `prerender` is high exactly while `line` equals that index.
- R3: `odd_frame` inverts at every return to dot 0 of line 0, whether or not the frame was shortened.
- R4: In short mode, if `odd_frame`=1 and `render_en`=1 in the cycle where pre-render `dot`=338, the cycle after `dot`=339 shows `dot`=0 and `line`=0. Such a frame lasts 341·LINES_SHORT−1 clocks, which is 89341 by default. A frame that is not shortened lasts 341·LINES_SHORT clocks, which is 89342 by default.
- R5: The skip depends only on `render_en` during pre-render dot 338. Dropping it during dot 339 still shortens the frame. Raising it only during dot 339 does not shorten the frame.
- R6: With `short_mode`=0 every frame lasts 341·LINES_FIXED clocks, odd or even.
- R7: `prefetch_a` is high at dot 321 and `prefetch_b` is high at dot 329, each only while `render_en`=1 and the line is below `VIS_LINES` or is the pre-render line.
- R8: `vscroll_copy` is high only on the pre-render line, with `render_en`=1, for dots 280 to 304 inclusive.
- R9: Asynchronous active-low reset sets `dot`=0, `line`=0 and `odd_frame`=0, and discards a latched skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| render_en | input | 1 | Rendering enabled level |
| short_mode | input | 1 | 1 = short-frame standard with odd-frame skip, 0 = fixed-length standard |
| dot | output | DOT_W | Current dot within the line |
| line | output | LINE_W | Current scanline within the frame |
| odd_frame | output | 1 | Frame parity |
| prerender | output | 1 | High on the pre-render line |
| prefetch_a | output | 1 | First tile-prefetch strobe (dot 321) |
| prefetch_b | output | 1 | Second tile-prefetch strobe (dot 329) |
| vscroll_copy | output | 1 | Vertical scroll copy window strobe |

## Verification
The bench measures whole-frame lengths, even against odd and short mode against fixed mode. A design that skipped on every frame, or never skipped, or skipped in fixed mode, gives a frame length off by one dot. The decision timing is probed two ways: by dropping rendering enable during dot 339, and by holding it low during 338 and raising it during 339. A design that samples enable at the wrap dot instead of the decision dot gets both cases backwards. A reset asserted while the skip is latched shows whether the flag survives reset, which would cut a later line short. A per-clock reference model also catches an off-by-one strobe window or a parity bit that fails to flip on a shortened frame.

// File: rtl/raster_pkg.sv
package raster_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE    = 2'd0,
        ST_PRERENDER = 2'd1,
        ST_ARMED     = 2'd2
    } line_state_e;

    localparam int PREFETCH_DOT_A = 321;
    localparam int PREFETCH_DOT_B = 329;
    localparam int VCOPY_FIRST    = 280;
    localparam int VCOPY_LAST     = 304;

endpackage

// File: rtl/raster_dot_ctr.sv
module raster_dot_ctr #(
    parameter int DOTS  = 341,
    parameter int DOT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cut,
    output logic [DOT_W-1:0] dot,
    output logic             line_end
);
    localparam logic [DOT_W-1:0] LAST = DOT_W'(DOTS - 1);

    assign line_end = (dot == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dot <= '0;
        else if (cut || line_end)
            dot <= '0;
        else
            dot <= dot + 1'b1;
    end

    AST_DOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dot <= LAST); // R1
    AST_DOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dot == LAST) |=> (dot == '0)); // R1
endmodule

// File: rtl/raster_line_fsm.sv
module raster_line_fsm
    import raster_pkg::*;
#(
    parameter int DOTS        = 341,
    parameter int DOT_W       = 9,
    parameter int LINES_SHORT = 262,
    parameter int LINES_FIXED = 312,
    parameter int LINE_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              render_en,
    input  logic              short_mode,
    input  logic [DOT_W-1:0]  dot,
    input  logic              line_end,
    output logic [LINE_W-1:0] line,
    output logic              odd_frame,
    output logic              prerender,
    output logic              cut
);
    localparam logic [DOT_W-1:0] DECIDE_DOT = DOT_W'(DOTS - 3);
    localparam logic [DOT_W-1:0] CUT_DOT    = DOT_W'(DOTS - 2);

    line_state_e state, nxt;
    logic [LINE_W-1:0] pre_idx;
    logic              frame_wrap;

    assign pre_idx = short_mode ? LINE_W'(LINES_SHORT - 1) : LINE_W'(LINES_FIXED - 1);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ACTIVE:
                if (line_end && ({1'b0, line} + 1'b1 >= {1'b0, pre_idx}))
                    nxt = ST_PRERENDER;
            ST_PRERENDER:
                if (line_end)
                    nxt = ST_ACTIVE;
                else if (dot == DECIDE_DOT && short_mode && render_en && odd_frame)
                    nxt = ST_ARMED;
            ST_ARMED:
                if (dot == CUT_DOT)
                    nxt = ST_ACTIVE;
            default:
                nxt = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_ACTIVE;
        else
            state <= nxt;
    end

    always_comb begin
        cut        = (state == ST_ARMED) && (dot == CUT_DOT);
        frame_wrap = cut || ((state == ST_PRERENDER) && line_end);
        prerender  = (state != ST_ACTIVE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line      <= '0;
            odd_frame <= 1'b0;
        end else if (frame_wrap) begin
            line      <= '0;
            odd_frame <= ~odd_frame;
        end else if (line_end) begin
            line <= (nxt == ST_PRERENDER) ? pre_idx : line + 1'b1;
        end
    end

    AST_ARMED_NEEDS_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) |-> odd_frame); // R4
    AST_ARMED_NEEDS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) |-> short_mode); // R6
    AST_CUT_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        cut |=> (dot == '0 && line == '0)); // R4
    AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (odd_frame != $past(odd_frame))); // R3
endmodule

// File: rtl/raster_strobes.sv
module raster_strobes
    import raster_pkg::*;
#(
    parameter int DOT_W     = 9,
    parameter int LINE_W    = 9,
    parameter int VIS_LINES = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    input  logic              prerender,
    input  logic              render_en,
    output logic              prefetch_a,
    output logic              prefetch_b,
    output logic              vscroll_copy
);
    logic fetch_line;

    always_comb begin
        fetch_line   = render_en && (prerender || ({1'b0, line} < (LINE_W+1)'(VIS_LINES)));
        prefetch_a   = fetch_line && (dot == DOT_W'(PREFETCH_DOT_A));
        prefetch_b   = fetch_line && (dot == DOT_W'(PREFETCH_DOT_B));
        vscroll_copy = render_en && prerender
                    && (dot >= DOT_W'(VCOPY_FIRST)) && (dot <= DOT_W'(VCOPY_LAST));
    end

    AST_VCOPY_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        vscroll_copy |-> (prerender && render_en)); // R8
    AST_FETCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prefetch_a, prefetch_b, vscroll_copy})); // R7
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
    parameter int DOTS_PER_LINE = 341,
    parameter int LINES_SHORT   = 262,
    parameter int LINES_FIXED   = 312,
    parameter int VIS_LINES     = 240,
    parameter int DOT_W         = $clog2(DOTS_PER_LINE),
    parameter int LINE_W        = $clog2((LINES_SHORT > LINES_FIXED) ? LINES_SHORT : LINES_FIXED)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              render_en,
    input  logic              short_mode,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line,
    output logic              odd_frame,
    output logic              prerender,
    output logic              prefetch_a,
    output logic              prefetch_b,
    output logic              vscroll_copy
);
    logic cut;
    logic line_end;

    raster_dot_ctr #(
        .DOTS  (DOTS_PER_LINE),
        .DOT_W (DOT_W)
    ) u_dot (
        .clk      (clk),
        .rst_n    (rst_n),
        .cut      (cut),
        .dot      (dot),
        .line_end (line_end)
    );

    raster_line_fsm #(
        .DOTS        (DOTS_PER_LINE),
        .DOT_W       (DOT_W),
        .LINES_SHORT (LINES_SHORT),
        .LINES_FIXED (LINES_FIXED),
        .LINE_W      (LINE_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .render_en  (render_en),
        .short_mode (short_mode),
        .dot        (dot),
        .line_end   (line_end),
        .line       (line),
        .odd_frame  (odd_frame),
        .prerender  (prerender),
        .cut        (cut)
    );

    raster_strobes #(
        .DOT_W     (DOT_W),
        .LINE_W    (LINE_W),
        .VIS_LINES (VIS_LINES)
    ) u_strb (
        .clk          (clk),
        .rst_n        (rst_n),
        .dot          (dot),
        .line         (line),
        .prerender    (prerender),
        .render_en    (render_en),
        .prefetch_a   (prefetch_a),
        .prefetch_b   (prefetch_b),
        .vscroll_copy (vscroll_copy)
    );

    AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_end && !cut) |=> $stable(line)); // R1
    AST_PRE_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        prerender |-> (line == (short_mode ? LINE_W'(LINES_SHORT - 1) : LINE_W'(LINES_FIXED - 1)))); // R2
endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_model #(
    parameter int LS  = 262,
    parameter int LF  = 312,
    parameter int VIS = 240,
    parameter string NAME = "big"
) (
    input logic clk,
    input logic rst_n,
    input logic render_en,
    input logic short_mode,
    input int   dot_i,
    input int   line_i,
    input logic odd_i,
    input logic pre_i,
    input logic fa_i,
    input logic fb_i,
    input logic vc_i
);
    int checks = 0;
    int fails  = 0;
    int rd = 0, rl = 0;
    bit ro = 0, rsk = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd = 0; rl = 0; ro = 0; rsk = 0;
        end else begin
            int pre;
            pre = (short_mode ? LS : LF) - 1;
            if (rl == pre && rd == 339 && rsk) begin
                rd = 0; rl = 0; ro = !ro; rsk = 0;
            end else if (rd == 340) begin
                rd = 0;
                if (rl == pre) begin rl = 0; ro = !ro; end
                else if (rl + 1 >= pre) rl = pre;
                else rl = rl + 1;
            end else begin
                if (rl == pre && rd == 338 && short_mode && render_en && ro) rsk = 1;
                rd = rd + 1;
            end
        end
    end

    always @(negedge clk) begin
        bit ep, efa, efb, evc, bad;
        ep  = (rl == (short_mode ? LS : LF) - 1);
        efa = render_en && (ep || rl < VIS) && rd == 321;
        efb = render_en && (ep || rl < VIS) && rd == 329;
        evc = render_en && ep && rd >= 280 && rd <= 304;
        bad = 0;
        checks++;
        if (dot_i != rd) begin bad = 1; $display("FAIL R1 %s dot act=%0d exp=%0d", NAME, dot_i, rd); end
        if (line_i != rl) begin bad = 1; $display("FAIL R2 %s line act=%0d exp=%0d", NAME, line_i, rl); end
        if (pre_i != ep) begin bad = 1; $display("FAIL R2 %s prerender act=%0d exp=%0d", NAME, pre_i, ep); end
        if (odd_i != ro) begin bad = 1; $display("FAIL R3 %s odd act=%0d exp=%0d", NAME, odd_i, ro); end
        if (fa_i != efa || fb_i != efb) begin bad = 1; $display("FAIL R7 %s prefetch act=%0d%0d exp=%0d%0d", NAME, fa_i, fb_i, efa, efb); end
        if (vc_i != evc) begin bad = 1; $display("FAIL R8 %s vcopy act=%0d exp=%0d", NAME, vc_i, evc); end
        if (bad) fails++;
    end
endmodule

module tb_raster_timing_gen;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // full-size instance
    logic b_rst_n = 1'b0, b_render = 1'b1, b_short = 1'b1;
    logic [8:0] b_dot, b_line;
    logic b_odd, b_pre, b_fa, b_fb, b_vc;

    raster_timing_gen dut (
        .clk(clk), .rst_n(b_rst_n), .render_en(b_render), .short_mode(b_short),
        .dot(b_dot), .line(b_line), .odd_frame(b_odd), .prerender(b_pre),
        .prefetch_a(b_fa), .prefetch_b(b_fb), .vscroll_copy(b_vc)
    );

    tb_raster_model #(.LS(262), .LF(312), .VIS(240), .NAME("big")) m_big (
        .clk(clk), .rst_n(b_rst_n), .render_en(b_render), .short_mode(b_short),
        .dot_i(int'(b_dot)), .line_i(int'(b_line)), .odd_i(b_odd), .pre_i(b_pre),
        .fa_i(b_fa), .fb_i(b_fb), .vc_i(b_vc)
    );

    // reduced instance for mode and corner coverage
    localparam int S_LS = 4, S_LF = 5;
    logic s_rst_n = 1'b0, s_render = 1'b1, s_short = 1'b1;
    logic [8:0] s_dot;
    logic [2:0] s_line;
    logic s_odd, s_pre, s_fa, s_fb, s_vc;

    raster_timing_gen #(.LINES_SHORT(S_LS), .LINES_FIXED(S_LF), .VIS_LINES(2)) dut_s (
        .clk(clk), .rst_n(s_rst_n), .render_en(s_render), .short_mode(s_short),
        .dot(s_dot), .line(s_line), .odd_frame(s_odd), .prerender(s_pre),
        .prefetch_a(s_fa), .prefetch_b(s_fb), .vscroll_copy(s_vc)
    );

    tb_raster_model #(.LS(S_LS), .LF(S_LF), .VIS(2), .NAME("small")) m_small (
        .clk(clk), .rst_n(s_rst_n), .render_en(s_render), .short_mode(s_short),
        .dot_i(int'(s_dot)), .line_i(int'(s_line)), .odd_i(s_odd), .pre_i(s_pre),
        .fa_i(s_fa), .fb_i(s_fb), .vc_i(s_vc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic frame_big(input int lo_at, output int n);
        n = 0;
        do begin
            @(posedge clk); #2;
            n++;
            if (b_line == 9'd261 && int'(b_dot) == lo_at) b_render = 1'b0;
        end while (!(b_dot == 0 && b_line == 0));
    endtask

    task automatic frame_small(input int lo_at, input int hi_at, output int n);
        n = 0;
        do begin
            int pre;
            @(posedge clk); #2;
            n++;
            pre = (s_short ? S_LS : S_LF) - 1;
            if (int'(s_line) == pre && int'(s_dot) == lo_at) s_render = 1'b0;
            if (int'(s_line) == pre && int'(s_dot) == hi_at) s_render = 1'b1;
        end while (!(s_dot == 0 && s_line == 0));
    endtask

    task automatic run_big();
        int n;
        repeat (3) @(posedge clk);
        #2 b_rst_n = 1'b1;
        chk(b_dot == 0 && b_line == 0 && b_odd == 0, "R9 big reset state", int'(b_dot) + int'(b_line) + int'(b_odd), 0);
        frame_big(-1, n);
        chk(n == 89342, "R4 even frame length", n, 89342);
        chk(b_odd == 1'b1, "R3 parity after even frame", int'(b_odd), 1);
        frame_big(339, n);
        chk(n == 89341, "R5 odd frame, enable dropped at dot 339", n, 89341);
        chk(b_odd == 1'b0, "R3 parity after short frame", int'(b_odd), 0);
    endtask

    task automatic run_small();
        int n;
        repeat (3) @(posedge clk);
        #2 s_rst_n = 1'b1;
        chk(s_dot == 0 && s_line == 0 && s_odd == 0, "R9 small reset state", int'(s_dot) + int'(s_line), 0);
        frame_small(-1, -1, n); chk(n == 1364, "R4 even frame full", n, 1364);
        frame_small(-1, -1, n); chk(n == 1363, "R4 odd frame short", n, 1363);
        frame_small(-1, -1, n); chk(n == 1364, "R4 even frame full again", n, 1364);
        frame_small(339, -1, n); chk(n == 1363, "R5 drop at 339 keeps skip", n, 1363);
        s_render = 1'b1;
        frame_small(-1, -1, n); chk(n == 1364, "R4 even after skip", n, 1364);
        frame_small(338, 339, n); chk(n == 1364, "R5 low at 338 high at 339 no skip", n, 1364);
        frame_small(-1, -1, n); chk(n == 1364, "R4 even frame", n, 1364);
        s_render = 1'b0;
        frame_small(-1, -1, n); chk(n == 1364, "R4 odd frame render off", n, 1364);
        chk(s_odd == 1'b0, "R3 parity after eight frames", int'(s_odd), 0);
        s_render = 1'b1;
        // fixed-length standard
        s_rst_n = 1'b0; s_short = 1'b0;
        repeat (2) @(posedge clk);
        #2 s_rst_n = 1'b1;
        frame_small(-1, -1, n); chk(n == 1705, "R6 fixed even frame", n, 1705);
        chk(s_odd == 1'b1, "R3 parity in fixed mode", int'(s_odd), 1);
        frame_small(-1, -1, n); chk(n == 1705, "R6 fixed odd frame no skip", n, 1705);
        // reset while the skip is latched
        s_rst_n = 1'b0; s_short = 1'b1;
        repeat (2) @(posedge clk);
        #2 s_rst_n = 1'b1;
        frame_small(-1, -1, n); chk(n == 1364, "R2 short frame after mode change", n, 1364);
        do begin @(posedge clk); #2; end while (!(s_line == 3'd3 && s_dot == 9'd339));
        s_rst_n = 1'b0;
        #1;
        chk(s_dot == 0 && s_line == 0 && s_odd == 0 && s_pre == 0, "R9 reset while armed",
            int'(s_dot) + int'(s_line) + int'(s_odd) + int'(s_pre), 0);
        repeat (2) @(posedge clk);
        #2 s_rst_n = 1'b1;
        frame_small(-1, -1, n); chk(n == 1364, "R9 no stale skip after reset", n, 1364);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks + m_big.checks + m_small.checks,
                 fails + m_big.fails + m_small.fails);
        $finish;
    end

    initial begin
        fork
            run_big();
            run_small();
        join
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks + m_big.checks + m_small.checks,
                 fails + m_big.fails + m_small.fails);
        $finish;
    end
endmodule